// File: doc/BRIEF.md
# Clock-Scheduled Dataflow Actor Wrapper

This block lets a stateless synchronous reaction run as an actor in a dataflow network. The reaction has a boolean selector input, two data inputs and one result. Each input arrives over two independent valid/ready channels: one carries the data token, the other carries a presence token that says whether this input takes part in the next reaction. The result leaves over a data channel and a presence channel. Every channel, at the input or the output, is backed by a single-entry register slot.

The wrapper fires a reaction only after it holds a presence token for every input, plus a data token for every input whose presence token is 1. Presence tokens therefore act as consumption orders. A data token whose presence is 0 is left in its slot for a later reaction, and a zero value is fed to the reaction in its place. When the selector is 1 and the first data input is present, the result is that input. When the selector is 0 and the second data input is present, the result is the second input. Any other presence pattern enables no guard. That is reported through a sticky error flag and produces no output.

Top module: `sched_actor_wrap`

## Requirements
- R1: No reaction fires and no token is consumed until all three presence slots (selector, data A, data B) are full. A missing presence token stalls the wrapper indefinitely.
- R2: If a presence token is 1 and the matching data slot is empty, the wrapper stalls without consuming anything. It fires once that data token arrives.
- R3: A data token whose presence token is 0 stays in its slot, with its ready low, and a later reaction whose presence for that input is 1 uses it unchanged.
- R4: With selector presence 1, selector value 1 and data-A presence 1, the result data token equals the data-A token and the result presence token is 1.
- R5: With selector presence 1, selector value 0 and data-B presence 1, the result data token equals the data-B token and the result presence token is 1.
- R6: A reaction that enables a guard places a result data token and a result presence token together. Both are held unchanged while the consumer keeps its ready low. A reaction consumes the three presence tokens and only the data tokens whose presence is 1.
- R7: A reaction that enables no guard sets `guard_err`, which stays at 1 until reset. Such a reaction consumes the three presence tokens, keeps every data token and places no result token. There are two cases: selector presence 0, or selector presence 1 with the branch it chooses absent.
- R8: Every channel holds at most one token, and its ready is low exactly while its slot is full. After reset every input ready is 1, both result valids are 0 and `guard_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_dat | input | 1 | Selector data token |
| sel_dat_vld | input | 1 | Selector data valid |
| sel_dat_rdy | output | 1 | Selector data slot empty |
| pa_dat | input | W | Data-A token |
| pa_dat_vld | input | 1 | Data-A valid |
| pa_dat_rdy | output | 1 | Data-A slot empty |
| pb_dat | input | W | Data-B token |
| pb_dat_vld | input | 1 | Data-B valid |
| pb_dat_rdy | output | 1 | Data-B slot empty |
| sel_pres | input | 1 | Selector presence token |
| sel_pres_vld | input | 1 | Selector presence valid |
| sel_pres_rdy | output | 1 | Selector presence slot empty |
| pa_pres | input | 1 | Data-A presence token |
| pa_pres_vld | input | 1 | Data-A presence valid |
| pa_pres_rdy | output | 1 | Data-A presence slot empty |
| pb_pres | input | 1 | Data-B presence token |
| pb_pres_vld | input | 1 | Data-B presence valid |
| pb_pres_rdy | output | 1 | Data-B presence slot empty |
| res_dat | output | W | Result data token |
| res_dat_vld | output | 1 | Result data valid |
| res_dat_rdy | input | 1 | Consumer accepts result data |
| res_pres | output | 1 | Result presence token |
| res_pres_vld | output | 1 | Result presence valid |
| res_pres_rdy | input | 1 | Consumer accepts result presence |
| guard_err | output | 1 | Sticky no-guard error |

## Verification
Each kind of wrong internal state shows up at the ports in its own way.

- A slot that drops or overwrites a held data token gives a wrong result value on the first later reaction whose presence for that input is 1. The data ready also rises one cycle early.
- A scheduler that fires too early consumes a presence token. Its ready goes high within one cycle of the edge, even though a result could not have been formed.
- A wrong guard shows as a result that takes the wrong branch, as a missing result, or as `guard_err` rising. Each of these appears one clock after the last needed token is accepted.

// File: rtl/actor_pkg.sv
package actor_pkg;
  localparam int NUM_IN = 3;
  localparam int IDX_SEL = 0;
  localparam int IDX_PA = 1;
  localparam int IDX_PB = 2;
  typedef logic [NUM_IN-1:0] presvec_t;
endpackage

// File: rtl/tok_slot.sv
module tok_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  output logic         in_rdy,
  input  logic [W-1:0] in_dat,
  output logic         out_vld,
  input  logic         out_pop,
  output logic [W-1:0] out_dat
);
  logic         full_q;
  logic [W-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (in_vld && !full_q) begin
      full_q <= 1'b1;
    end else if (out_pop && full_q) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_vld && !full_q) dat_q <= in_dat;
  end

  assign in_rdy  = !full_q;
  assign out_vld = full_q;
  assign out_dat = dat_q;

  // A held token is never changed or lost while nobody pops it
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (full_q && !out_pop) |=> (full_q && $stable(dat_q)));
endmodule

// File: rtl/guard_eval.sv
module guard_eval #(
  parameter int W = 8
) (
  input  actor_pkg::presvec_t pres,
  input  logic                sel_raw,
  input  logic [W-1:0]        pa_raw,
  input  logic [W-1:0]        pb_raw,
  output logic                y_pres,
  output logic [W-1:0]        y_val
);
  import actor_pkg::*;
  logic         sel_v;
  logic [W-1:0] pa_v;
  logic [W-1:0] pb_v;

  // absent inputs are replaced by zero
  always_comb begin
    sel_v = pres[IDX_SEL] ? sel_raw : 1'b0;
    pa_v  = pres[IDX_PA]  ? pa_raw  : '0;
    pb_v  = pres[IDX_PB]  ? pb_raw  : '0;
    y_pres = pres[IDX_SEL] &&
             ((pres[IDX_PA] && sel_v) || (pres[IDX_PB] && !sel_v));
    y_val  = sel_v ? pa_v : pb_v;
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl (
  input  actor_pkg::presvec_t tok_full,
  input  actor_pkg::presvec_t tok_val,
  input  actor_pkg::presvec_t dat_full,
  input  logic                out_free,
  input  logic                guard_ok,
  output logic                fire,
  output logic                pop_tok,
  output actor_pkg::presvec_t pop_dat,
  output logic                push_out,
  output logic                err_set
);
  logic all_tok;
  logic data_ok;

  always_comb begin
    all_tok  = &tok_full;
    data_ok  = &(~tok_val | dat_full);
    fire     = all_tok && data_ok && out_free;
    pop_tok  = fire;
    push_out = fire && guard_ok;
    err_set  = fire && !guard_ok;
    pop_dat  = push_out ? tok_val : '0;
  end
endmodule

// File: rtl/sched_actor_wrap.sv
module sched_actor_wrap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_dat,
  input  logic         sel_dat_vld,
  output logic         sel_dat_rdy,
  input  logic [W-1:0] pa_dat,
  input  logic         pa_dat_vld,
  output logic         pa_dat_rdy,
  input  logic [W-1:0] pb_dat,
  input  logic         pb_dat_vld,
  output logic         pb_dat_rdy,
  input  logic         sel_pres,
  input  logic         sel_pres_vld,
  output logic         sel_pres_rdy,
  input  logic         pa_pres,
  input  logic         pa_pres_vld,
  output logic         pa_pres_rdy,
  input  logic         pb_pres,
  input  logic         pb_pres_vld,
  output logic         pb_pres_rdy,
  output logic [W-1:0] res_dat,
  output logic         res_dat_vld,
  input  logic         res_dat_rdy,
  output logic         res_pres,
  output logic         res_pres_vld,
  input  logic         res_pres_rdy,
  output logic         guard_err
);
  import actor_pkg::*;

  presvec_t tin_vld, tin_val, tin_rdy, tok_full, tok_val;
  presvec_t dat_full, pop_dat;
  logic     fire, pop_tok, push_out, err_set;
  logic     y_pres;
  logic [W-1:0] y_val;
  logic     sel_q;
  logic [W-1:0] wide_in  [1:2];
  logic         wide_vld [1:2];
  logic         wide_rdy [1:2];
  logic [W-1:0] wide_q   [1:2];
  logic     od_rdy, op_rdy;
  logic     err_q;

  assign tin_vld = {pb_pres_vld, pa_pres_vld, sel_pres_vld};
  assign tin_val = {pb_pres, pa_pres, sel_pres};
  assign {pb_pres_rdy, pa_pres_rdy, sel_pres_rdy} = tin_rdy;

  // presence slots, one per input
  for (genvar i = 0; i < NUM_IN; i++) begin : g_pres
    logic [0:0] q;
    tok_slot #(.W(1)) u_slot (
      .clk(clk), .rst(rst),
      .in_vld(tin_vld[i]), .in_rdy(tin_rdy[i]), .in_dat(tin_val[i]),
      .out_vld(tok_full[i]), .out_pop(pop_tok), .out_dat(q)
    );
    assign tok_val[i] = q[0];
  end

  // selector data slot
  tok_slot #(.W(1)) u_sel (
    .clk(clk), .rst(rst),
    .in_vld(sel_dat_vld), .in_rdy(sel_dat_rdy), .in_dat(sel_dat),
    .out_vld(dat_full[IDX_SEL]), .out_pop(pop_dat[IDX_SEL]), .out_dat(sel_q)
  );

  assign wide_in[1]  = pa_dat;
  assign wide_in[2]  = pb_dat;
  assign wide_vld[1] = pa_dat_vld;
  assign wide_vld[2] = pb_dat_vld;
  assign pa_dat_rdy  = wide_rdy[1];
  assign pb_dat_rdy  = wide_rdy[2];

  // wide data slots
  for (genvar j = 1; j < NUM_IN; j++) begin : g_dat
    tok_slot #(.W(W)) u_slot (
      .clk(clk), .rst(rst),
      .in_vld(wide_vld[j]), .in_rdy(wide_rdy[j]), .in_dat(wide_in[j]),
      .out_vld(dat_full[j]), .out_pop(pop_dat[j]), .out_dat(wide_q[j])
    );
  end

  guard_eval #(.W(W)) u_guard (
    .pres(tok_val), .sel_raw(sel_q), .pa_raw(wide_q[1]), .pb_raw(wide_q[2]),
    .y_pres(y_pres), .y_val(y_val)
  );

  sched_ctrl u_sched (
    .tok_full(tok_full), .tok_val(tok_val), .dat_full(dat_full),
    .out_free(od_rdy && op_rdy), .guard_ok(y_pres),
    .fire(fire), .pop_tok(pop_tok), .pop_dat(pop_dat),
    .push_out(push_out), .err_set(err_set)
  );

  // result slots
  tok_slot #(.W(W)) u_res_dat (
    .clk(clk), .rst(rst),
    .in_vld(push_out), .in_rdy(od_rdy), .in_dat(y_val),
    .out_vld(res_dat_vld), .out_pop(res_dat_rdy), .out_dat(res_dat)
  );

  tok_slot #(.W(1)) u_res_pres (
    .clk(clk), .rst(rst),
    .in_vld(push_out), .in_rdy(op_rdy), .in_dat(y_pres),
    .out_vld(res_pres_vld), .out_pop(res_pres_rdy), .out_dat(res_pres)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end
  assign guard_err = err_q;

  // a result appears only after every presence slot was full
  assert_fire_all_pres_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(res_pres_vld) |-> $past(!sel_pres_rdy && !pa_pres_rdy && !pb_pres_rdy));

  // result data and result presence are placed together
  assert_pair_push_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(res_dat_vld) |-> $rose(res_pres_vld));

  // the error flag never clears on its own
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $past(guard_err) |-> guard_err);

  // a no-guard reaction places no result
  assert_err_no_push_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(guard_err) |-> !$rose(res_pres_vld));
endmodule

// File: tb/tb_sched_actor_wrap.sv
module tb_sched_actor_wrap;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_dat = 1'b0, sel_dat_vld = 1'b0, sel_dat_rdy;
  logic [W-1:0] pa_dat = '0, pb_dat = '0;
  logic pa_dat_vld = 1'b0, pa_dat_rdy, pb_dat_vld = 1'b0, pb_dat_rdy;
  logic sel_pres = 1'b0, sel_pres_vld = 1'b0, sel_pres_rdy;
  logic pa_pres = 1'b0, pa_pres_vld = 1'b0, pa_pres_rdy;
  logic pb_pres = 1'b0, pb_pres_vld = 1'b0, pb_pres_rdy;
  logic [W-1:0] res_dat;
  logic res_dat_vld, res_dat_rdy = 1'b0, res_pres, res_pres_vld, res_pres_rdy = 1'b0;
  logic guard_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic         mfull [3];
  logic [W-1:0] mval  [3];

  always #2.5 clk = ~clk;

  sched_actor_wrap #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic rdy_of(input int ch);
    case (ch)
      0: return sel_dat_rdy;
      1: return pa_dat_rdy;
      2: return pb_dat_rdy;
      3: return sel_pres_rdy;
      4: return pa_pres_rdy;
      default: return pb_pres_rdy;
    endcase
  endfunction

  task automatic drive(input int ch, input logic v, input logic [W-1:0] d);
    case (ch)
      0: begin sel_dat_vld = v; sel_dat = d[0]; end
      1: begin pa_dat_vld = v; pa_dat = d; end
      2: begin pb_dat_vld = v; pb_dat = d; end
      3: begin sel_pres_vld = v; sel_pres = d[0]; end
      4: begin pa_pres_vld = v; pa_pres = d[0]; end
      default: begin pb_pres_vld = v; pb_pres = d[0]; end
    endcase
  endtask

  task automatic push(input int ch, input logic [W-1:0] d);
    @(negedge clk);
    while (!rdy_of(ch)) @(negedge clk);
    drive(ch, 1'b1, d);
    @(negedge clk);
    drive(ch, 1'b0, '0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) mfull[i] = 1'b0;
    @(negedge clk);
  endtask

  // expected result presence from the guard rules
  function automatic logic exp_pres(input logic [2:0] c, input logic s);
    return c[0] && ((c[1] && s) || (c[2] && !s));
  endfunction

  task automatic pop_result();
    res_dat_rdy = 1'b1; res_pres_rdy = 1'b1;
    @(negedge clk);
    res_dat_rdy = 1'b0; res_pres_rdy = 1'b0;
  endtask

  // one reaction: c = presence per input, extra = also park data on absent inputs
  task automatic react(input logic [2:0] c, input logic [2:0] extra,
                       input logic selv, input int hold, input string req);
    logic s;
    logic [W-1:0] e;
    int t;
    for (int i = 0; i < 3; i++) begin
      if (!mfull[i] && (c[i] || extra[i])) begin
        mval[i] = (i == 0) ? W'(selv) : W'($urandom);
        mfull[i] = 1'b1;
        push(i, mval[i]);
      end
    end
    for (int i = 0; i < 3; i++) push(3 + i, W'(c[i]));
    s = mval[0][0];
    if (exp_pres(c, s)) begin
      e = s ? mval[1] : mval[2];
      t = 0;
      while (!res_dat_vld && t < 40) begin @(negedge clk); t++; end
      chk(res_dat_vld && res_pres_vld, {req, " result placed"}, res_dat_vld, 1);
      chk(res_dat == e, {req, " result value"}, res_dat, e);
      chk(res_pres == 1'b1, {req, " result presence"}, res_pres, 1);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk(res_dat_vld && res_dat == e, "R6 held under backpressure", res_dat, e);
      end
      pop_result();
      for (int i = 0; i < 3; i++) if (c[i]) mfull[i] = 1'b0;
    end else begin
      repeat (6) @(negedge clk);
      chk(!res_pres_vld && !res_dat_vld, "R7 no result", res_pres_vld, 0);
      chk(guard_err == 1'b1, "R7 error flag", guard_err, 1);
      chk(sel_pres_rdy && pa_pres_rdy && pb_pres_rdy, "R7 presence consumed",
          {sel_pres_rdy, pa_pres_rdy, pb_pres_rdy}, 7);
    end
    @(negedge clk);
    chk(sel_dat_rdy == !mfull[0] && pa_dat_rdy == !mfull[1] && pb_dat_rdy == !mfull[2],
        "R3 data slots after reaction", {sel_dat_rdy, pa_dat_rdy, pb_dat_rdy},
        {!mfull[0], !mfull[1], !mfull[2]});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R8 reset state
    chk(sel_dat_rdy && pa_dat_rdy && pb_dat_rdy && sel_pres_rdy && pa_pres_rdy && pb_pres_rdy,
        "R8 readies after reset", 0, 1);
    chk(!res_dat_vld && !res_pres_vld && !guard_err, "R8 outputs after reset",
        {res_dat_vld, res_pres_vld, guard_err}, 0);

    react(3'b111, 3'b000, 1'b1, 0, "R4");
    react(3'b101, 3'b000, 1'b0, 0, "R5");
    react(3'b011, 3'b000, 1'b1, 3, "R6");

    // R1: presence for data B missing
    mval[0] = W'(1); mval[1] = 8'h5a; mval[2] = '0;
    push(0, mval[0]); push(1, mval[1]);
    push(3, W'(1)); push(4, W'(1));
    repeat (6) @(negedge clk);
    chk(!res_pres_vld, "R1 stall without all presence", res_pres_vld, 0);
    chk(!sel_pres_rdy && !sel_dat_rdy, "R1 nothing consumed", sel_pres_rdy, 0);
    chk(!pa_dat_rdy, "R8 ready low while full", pa_dat_rdy, 0);
    push(5, W'(0));
    repeat (3) @(negedge clk);
    chk(res_dat_vld && res_dat == 8'h5a, "R1 fires after last presence", res_dat, 8'h5a);
    pop_result();

    // R2: data A presence set but token missing
    push(0, W'(1));
    push(3, W'(1)); push(4, W'(1)); push(5, W'(0));
    repeat (6) @(negedge clk);
    chk(!res_pres_vld && !sel_dat_rdy && !sel_pres_rdy, "R2 stall without data",
        res_pres_vld, 0);
    push(1, 8'hc3);
    repeat (3) @(negedge clk);
    chk(res_dat_vld && res_dat == 8'hc3, "R2 fires after data", res_dat, 8'hc3);
    pop_result();
    @(negedge clk);

    // R3: park a data-B token, use it later
    for (int i = 0; i < 3; i++) mfull[i] = 1'b0;
    react(3'b011, 3'b100, 1'b1, 0, "R3 park");
    chk(!pb_dat_rdy, "R3 parked token held", pb_dat_rdy, 0);
    react(3'b101, 3'b000, 1'b0, 1, "R3 reuse");

    // mixed random reactions
    for (int n = 0; n < 150; n++) begin
      logic [2:0] c;
      logic s;
      c = 3'($urandom);
      c[0] = 1'b1;
      s = mfull[0] ? mval[0][0] : 1'($urandom);
      if (s) c[1] = 1'b1; else c[2] = 1'b1;
      react(c, 3'($urandom), s, $urandom_range(0, 2), s ? "R4 random" : "R5 random");
    end

    // R7: selector absent
    do_reset();
    react(3'b110, 3'b000, 1'b1, 0, "R7 sel absent");
    // R7: chosen branch absent, data kept
    do_reset();
    react(3'b011, 3'b000, 1'b0, 0, "R7 branch absent");
    chk(!sel_dat_rdy, "R7 selector data kept", sel_dat_rdy, 0);
    repeat (4) @(negedge clk);
    chk(guard_err, "R7 flag stays set", guard_err, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule